// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block sits beside a processor's bus and watches every bus cycle. Two channels, A and B, each hold a compare address with a per-bit ignore mask, plus a condition word that narrows the match by cycle kind (instruction fetch or operand access), direction, access size and, if wanted, an 8-bit address-space identifier. Channel B also compares the data bus under its own ignore mask. When the programmed conditions are met, the block issues a one-cycle break request to the exception logic, which takes the break before a matched fetch executes.

A mode bit selects how the channels combine. In independent mode either channel raises the break by itself. In sequence mode a channel B match raises the break only when a channel A match came earlier. Each channel also has a sticky match flag that software clears by writing zero. Configuration is loaded through a simple write-only register port.

Top module: `bus_break_unit`

## Requirements
- R1: After reset, brk_req, match_a_flag and match_b_flag are 0 and both channels are disabled, so no bus cycle produces a match until a channel's enable bit is written.
- R2: A channel's address matches when (bus_addr XOR compare address) AND NOT mask is zero; a mask bit of 1 ignores that address bit, and a zero mask demands an exact address.
- R3: Cycle-kind field, condition bits [1:0]: 00 any, 01 fetch only (bus_fetch=1), 10 operand only (bus_fetch=0), 11 never matches; fetches are taken at even addresses, so a fetch condition programmed with an odd exact address never matches.
- R4: Direction field, condition bits [3:2]: 00 any, 01 read, 10 write, 11 never matches; a fetch counts as a read whatever bus_write holds, so a write condition never matches a fetch.
- R5: Size field, condition bits [5:4]: 00 any, otherwise it must equal bus_size, where 01 is byte, 10 is word, 11 is longword.
- R6: Condition bit 6 enables the identifier check; when set the channel matches only if bus_asid equals condition bits [15:8]; when clear bus_asid is ignored.
- R7: Channel B also requires (bus_data XOR compare data) AND NOT data mask to be zero; channel A ignores bus_data entirely.
- R8: In independent mode (mode bit 0 = 0) a match on either channel, or both, drives brk_req high for exactly the one cycle that follows the matching bus cycle.
- R9: In sequence mode (mode bit 0 = 1) a channel A match alone does not break; a later channel B match breaks and consumes the A record; a B match with no earlier A match, or in the same cycle as an A match, does not break, though that A match is still recorded.
- R10: Any write to the mode register discards a recorded channel A match.
- R11: match_a_flag and match_b_flag go high in the cycle after their channel matches, in either mode, and stay high; writing the flag register with bit 0 (A) or bit 1 (B) equal to 0 clears that flag, a 1 leaves it, and a match in the same cycle as a clear wins.
- R12: Register offsets on cfg_addr: 0 A address, 1 A mask, 2 A condition, 3 B address, 4 B mask, 5 B condition, 6 B data, 7 B data mask, 8 mode, 9 flag clear; a written value takes effect from the next cycle.
- R13: Condition bit 7 enables the channel; with it clear the channel never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = operand access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 01 byte, 10 word, 11 longword |
| bus_addr | input | 32 | Bus cycle address |
| bus_data | input | 32 | Bus cycle data |
| bus_asid | input | 8 | Current address-space identifier |
| brk_req | output | 1 | One-cycle break request |
| match_a_flag | output | 1 | Sticky channel A match flag |
| match_b_flag | output | 1 | Sticky channel B match flag |

## Verification
A wrong internal state shows up at the ports within one cycle of the next bus cycle that touches it: a stale or spurious channel A record in sequence mode turns the next channel B match into a break, or suppresses one, on brk_req one cycle later. A corrupted sticky flag is visible on its own pin from the next cycle and stays wrong until cleared, so the bench compares both flags after every driven cycle and after each clear write. A compare field decoded wrongly appears as a missed or extra pulse on the cycle right after the crafted bus cycle that differs from the programmed condition in that one field.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int BRK_IDW = 8;
  localparam int BRK_RAW = 4;

  typedef enum logic [1:0] {
    KIND_ANY   = 2'b00,
    KIND_FETCH = 2'b01,
    KIND_OPER  = 2'b10,
    KIND_NONE  = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    DIR_ANY  = 2'b00,
    DIR_RD   = 2'b01,
    DIR_WR   = 2'b10,
    DIR_NONE = 2'b11
  } dir_e;

  typedef enum logic [1:0] {
    SZ_ANY  = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LONG = 2'b11
  } size_e;

  // Condition word layout, MSB first: id[15:8] en[7] id_en[6] size[5:4] dir[3:2] kind[1:0]
  typedef struct packed {
    logic [BRK_IDW-1:0] id;
    logic               en;
    logic               id_en;
    size_e              size;
    dir_e               dir;
    kind_e              kind;
  } cond_t;

  localparam int COND_W = $bits(cond_t);

  localparam logic [BRK_RAW-1:0] OFS_A_ADDR  = 4'd0;
  localparam logic [BRK_RAW-1:0] OFS_A_MASK  = 4'd1;
  localparam logic [BRK_RAW-1:0] OFS_A_COND  = 4'd2;
  localparam logic [BRK_RAW-1:0] OFS_B_ADDR  = 4'd3;
  localparam logic [BRK_RAW-1:0] OFS_B_MASK  = 4'd4;
  localparam logic [BRK_RAW-1:0] OFS_B_COND  = 4'd5;
  localparam logic [BRK_RAW-1:0] OFS_B_DATA  = 4'd6;
  localparam logic [BRK_RAW-1:0] OFS_B_DMASK = 4'd7;
  localparam logic [BRK_RAW-1:0] OFS_MODE    = 4'd8;
  localparam logic [BRK_RAW-1:0] OFS_FLAGS   = 4'd9;

endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int WW = (AW > DW) ? AW : DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [BRK_RAW-1:0] addr,
  input  logic [WW-1:0]      wdata,
  output logic [AW-1:0]      a_addr,
  output logic [AW-1:0]      a_mask,
  output cond_t              a_cond,
  output logic [AW-1:0]      b_addr,
  output logic [AW-1:0]      b_mask,
  output cond_t              b_cond,
  output logic [DW-1:0]      b_data,
  output logic [DW-1:0]      b_dmask,
  output logic               seq_mode,
  output logic               mode_wr,
  output logic               flag_wr,
  output logic [1:0]         flag_wdata
);

  logic we_a_addr, we_a_mask, we_a_cond;
  logic we_b_addr, we_b_mask, we_b_cond, we_b_data, we_b_dmask;
  cond_t wcond;

  always_comb begin
    we_a_addr  = we && (addr == OFS_A_ADDR);
    we_a_mask  = we && (addr == OFS_A_MASK);
    we_a_cond  = we && (addr == OFS_A_COND);
    we_b_addr  = we && (addr == OFS_B_ADDR);
    we_b_mask  = we && (addr == OFS_B_MASK);
    we_b_cond  = we && (addr == OFS_B_COND);
    we_b_data  = we && (addr == OFS_B_DATA);
    we_b_dmask = we && (addr == OFS_B_DMASK);
    mode_wr    = we && (addr == OFS_MODE);
    flag_wr    = we && (addr == OFS_FLAGS);
    flag_wdata = wdata[1:0];
    wcond      = cond_t'(wdata[COND_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_addr   <= '0;
      a_mask   <= '0;
      a_cond   <= '0;
      b_addr   <= '0;
      b_mask   <= '0;
      b_cond   <= '0;
      b_data   <= '0;
      b_dmask  <= '0;
      seq_mode <= 1'b0;
    end else begin
      if (we_a_addr)  a_addr   <= wdata[AW-1:0];
      if (we_a_mask)  a_mask   <= wdata[AW-1:0];
      if (we_a_cond)  a_cond   <= wcond;
      if (we_b_addr)  b_addr   <= wdata[AW-1:0];
      if (we_b_mask)  b_mask   <= wdata[AW-1:0];
      if (we_b_cond)  b_cond   <= wcond;
      if (we_b_data)  b_data   <= wdata[DW-1:0];
      if (we_b_dmask) b_dmask  <= wdata[DW-1:0];
      if (mode_wr)    seq_mode <= wdata[0];
    end
  end

endmodule

// File: rtl/brk_chan_match.sv
module brk_chan_match
  import brk_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter bit HAS_DATA = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      cmp_addr,
  input  logic [AW-1:0]      cmp_amask,
  input  cond_t              cond,
  input  logic [DW-1:0]      cmp_data,
  input  logic [DW-1:0]      cmp_dmask,
  input  logic               bus_valid,
  input  logic               bus_fetch,
  input  logic               bus_write,
  input  logic [1:0]         bus_size,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_data,
  input  logic [BRK_IDW-1:0] bus_asid,
  output logic               hit
);

  logic addr_ok, kind_ok, dir_ok, size_ok, id_ok, data_ok;
  logic eff_write;

  generate
    if (HAS_DATA) begin : g_data
      assign data_ok = ~|((bus_data ^ cmp_data) & ~cmp_dmask);
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{bus_data, cmp_data, cmp_dmask};
      assign data_ok     = 1'b1;
    end
  endgenerate

  always_comb begin
    // A fetch is always a read, whatever the write attribute says.
    eff_write = bus_write && !bus_fetch;
    addr_ok   = ~|((bus_addr ^ cmp_addr) & ~cmp_amask);
    unique case (cond.kind)
      KIND_ANY:   kind_ok = 1'b1;
      KIND_FETCH: kind_ok = bus_fetch;
      KIND_OPER:  kind_ok = !bus_fetch;
      default:    kind_ok = 1'b0;
    endcase
    unique case (cond.dir)
      DIR_ANY: dir_ok = 1'b1;
      DIR_RD:  dir_ok = !eff_write;
      DIR_WR:  dir_ok = eff_write;
      default: dir_ok = 1'b0;
    endcase
    size_ok = (cond.size == SZ_ANY) || (bus_size == cond.size);
    id_ok   = !cond.id_en || (bus_asid == cond.id);
    hit     = bus_valid && cond.en && addr_ok && kind_ok && dir_ok
              && size_ok && id_ok && data_ok;
  end

  // R4: a fetch never satisfies a write condition.
  assert_fetch_not_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_fetch && cond.dir == DIR_WR) |-> !hit);

endmodule

// File: rtl/brk_seq_ctrl.sv
module brk_seq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_hit,
  input  logic       b_hit,
  input  logic       seq_mode,
  input  logic       mode_wr,
  input  logic       flag_wr,
  input  logic [1:0] flag_wdata,
  output logic       brk_req,
  output logic       flag_a,
  output logic       flag_b
);

  logic seen_q, seen_d;
  logic req_q, req_d;
  logic fa_q, fa_d, fb_q, fb_d;
  logic clr_a, clr_b;

  always_comb begin
    if (seq_mode) begin
      req_d = b_hit && seen_q && !a_hit;
    end else begin
      req_d = a_hit || b_hit;
    end

    seen_d = seen_q;
    if (mode_wr || !seq_mode) begin
      seen_d = 1'b0;
    end else if (req_d) begin
      seen_d = 1'b0;
    end else if (a_hit) begin
      seen_d = 1'b1;
    end

    clr_a = flag_wr && !flag_wdata[0];
    clr_b = flag_wr && !flag_wdata[1];
    fa_d  = a_hit || (fa_q && !clr_a);
    fb_d  = b_hit || (fb_q && !clr_b);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      req_q  <= 1'b0;
      fa_q   <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      seen_q <= seen_d;
      req_q  <= req_d;
      fa_q   <= fa_d;
      fb_q   <= fb_d;
    end
  end

  assign brk_req = req_q;
  assign flag_a  = fa_q;
  assign flag_b  = fb_q;

  // R9: a break always consumes the recorded channel A match.
  assert_seen_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !seen_q);

  // R10: outside sequence mode no A record is ever held.
  assert_no_record_indep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_mode |-> !seen_q);

  // R11: a break is always accompanied by a raised sticky flag.
  assert_flag_with_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (fa_q || fb_q));

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int WW = (AW > DW) ? AW : DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [BRK_RAW-1:0] cfg_addr,
  input  logic [WW-1:0]      cfg_wdata,
  input  logic               bus_valid,
  input  logic               bus_fetch,
  input  logic               bus_write,
  input  logic [1:0]         bus_size,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_data,
  input  logic [BRK_IDW-1:0] bus_asid,
  output logic               brk_req,
  output logic               match_a_flag,
  output logic               match_b_flag
);

  logic [AW-1:0] a_addr, a_mask, b_addr, b_mask;
  logic [DW-1:0] b_data, b_dmask;
  cond_t         a_cond, b_cond;
  logic          seq_mode, mode_wr, flag_wr;
  logic [1:0]    flag_wdata;
  logic          a_hit, b_hit;

  brk_cfg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .a_addr     (a_addr),
    .a_mask     (a_mask),
    .a_cond     (a_cond),
    .b_addr     (b_addr),
    .b_mask     (b_mask),
    .b_cond     (b_cond),
    .b_data     (b_data),
    .b_dmask    (b_dmask),
    .seq_mode   (seq_mode),
    .mode_wr    (mode_wr),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata)
  );

  brk_chan_match #(.AW(AW), .DW(DW), .HAS_DATA(1'b0)) u_chan_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_addr  (a_addr),
    .cmp_amask (a_mask),
    .cond      (a_cond),
    .cmp_data  ('0),
    .cmp_dmask ('1),
    .bus_valid (bus_valid),
    .bus_fetch (bus_fetch),
    .bus_write (bus_write),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_asid  (bus_asid),
    .hit       (a_hit)
  );

  brk_chan_match #(.AW(AW), .DW(DW), .HAS_DATA(1'b1)) u_chan_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_addr  (b_addr),
    .cmp_amask (b_mask),
    .cond      (b_cond),
    .cmp_data  (b_data),
    .cmp_dmask (b_dmask),
    .bus_valid (bus_valid),
    .bus_fetch (bus_fetch),
    .bus_write (bus_write),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_asid  (bus_asid),
    .hit       (b_hit)
  );

  brk_seq_ctrl u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_hit      (a_hit),
    .b_hit      (b_hit),
    .seq_mode   (seq_mode),
    .mode_wr    (mode_wr),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .brk_req    (brk_req),
    .flag_a     (match_a_flag),
    .flag_b     (match_b_flag)
  );

  // R8: a break request only ever follows a presented bus cycle.
  assert_req_after_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(bus_valid));

endmodule

// File: tb/bus_break_unit_bench.sv
`timescale 1ns/1ps
module bus_break_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        bus_valid, bus_fetch, bus_write;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_data;
  logic [7:0]  bus_asid;
  logic        brk_req, match_a_flag, match_b_flag;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  logic exp_fa = 1'b0;
  logic exp_fb = 1'b0;

  int         due_q[$];
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  bus_break_unit u_bus_break_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .bus_valid    (bus_valid),
    .bus_fetch    (bus_fetch),
    .bus_write    (bus_write),
    .bus_size     (bus_size),
    .bus_addr     (bus_addr),
    .bus_data     (bus_data),
    .bus_asid     (bus_asid),
    .brk_req      (brk_req),
    .match_a_flag (match_a_flag),
    .match_b_flag (match_b_flag)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expectations whose cycle has come and compares outputs.
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      logic [2:0] e;
      logic [2:0] act;
      string      t;
      void'(due_q.pop_front());
      e   = exp_q.pop_front();
      t   = tag_q.pop_front();
      act = {brk_req, match_a_flag, match_b_flag};
      tests++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s: {req,fa,fb} actual %b expected %b", t, act, e);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] a, input logic [31:0] d);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic clear_flags(input logic [1:0] keep);
    cfg(4'd9, {30'd0, keep});
    exp_fa = exp_fa & keep[0];
    exp_fb = exp_fb & keep[1];
  endtask

  // Driver: one bus cycle then one idle cycle; expectations go to the scoreboard.
  task automatic bus(input logic f, input logic w, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] d, input logic [7:0] id,
                     input logic ea, input logic eb, input logic er, input string tag);
    bus_valid = 1'b1;
    bus_fetch = f;
    bus_write = w;
    bus_size  = sz;
    bus_addr  = a;
    bus_data  = d;
    bus_asid  = id;
    exp_fa    = exp_fa | ea;
    exp_fb    = exp_fb | eb;
    due_q.push_back(cyc + 1);
    exp_q.push_back({er, exp_fa, exp_fb});
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
    due_q.push_back(cyc + 1);
    exp_q.push_back({1'b0, exp_fa, exp_fb});
    tag_q.push_back({tag, " R8 pulse ends"});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    bus_valid = 1'b0; bus_fetch = 1'b0; bus_write = 1'b0; bus_size = '0;
    bus_addr = '0; bus_data = '0; bus_asid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 brk_req after reset", brk_req, 0);
    chk("R1 flags after reset", {match_a_flag, match_b_flag}, 0);
    bus(0, 0, 2'b00, 32'h0, 32'h0, 8'h0, 0, 0, 0, "R1 disabled channels");

    // Channel A: enabled, operand, write, word -> cond 0x00AA (R12 offsets)
    cfg(4'd0, 32'h1000); cfg(4'd1, 32'h0); cfg(4'd2, 32'h00AA); cfg(4'd8, 32'h0);
    bus(0, 1, 2'b10, 32'h1000, 32'h5, 8'h0, 1, 0, 1, "R8 R12 A operand write word");
    bus(0, 0, 2'b10, 32'h1000, 32'h5, 8'h0, 0, 0, 0, "R4 read vs write cond");
    bus(0, 1, 2'b01, 32'h1000, 32'h5, 8'h0, 0, 0, 0, "R5 byte vs word cond");
    bus(1, 1, 2'b10, 32'h1000, 32'h5, 8'h0, 0, 0, 0, "R3 fetch vs operand cond");
    bus(0, 1, 2'b10, 32'h1004, 32'h5, 8'h0, 0, 0, 0, "R2 exact address miss");
    cfg(4'd1, 32'h0000_000F);
    bus(0, 1, 2'b10, 32'h1004, 32'h5, 8'h0, 1, 0, 1, "R2 masked address hit");
    bus(0, 1, 2'b10, 32'h1010, 32'h5, 8'h0, 0, 0, 0, "R2 unmasked bit miss");
    cfg(4'd1, 32'h0);
    cfg(4'd2, 32'h00A8);  // any kind, write, word
    bus(1, 1, 2'b10, 32'h1000, 32'h5, 8'h0, 0, 0, 0, "R4 fetch is a read");
    bus(0, 1, 2'b10, 32'h1000, 32'hDEADBEEF, 8'h0, 1, 0, 1, "R7 A ignores data");
    cfg(4'd2, 32'h80C0);  // enabled, id check 0x80, rest any
    bus(1, 0, 2'b11, 32'h1000, 32'h0, 8'h80, 1, 0, 1, "R6 id equal");
    bus(1, 0, 2'b11, 32'h1000, 32'h0, 8'h70, 0, 0, 0, "R6 id differs");
    cfg(4'd2, 32'h8040);
    bus(1, 0, 2'b11, 32'h1000, 32'h0, 8'h80, 0, 0, 0, "R13 enable clear");
    cfg(4'd2, 32'h80C0);

    // Channel B: enabled, fetch, read, any size -> cond 0x0085
    cfg(4'd3, 32'h2000); cfg(4'd4, 32'h0); cfg(4'd5, 32'h0085);
    cfg(4'd6, 32'h1234_5678); cfg(4'd7, 32'h0000_FFFF);
    bus(1, 0, 2'b10, 32'h2000, 32'h1234_ABCD, 8'h0, 0, 1, 1, "R7 data under mask");
    bus(1, 0, 2'b10, 32'h2000, 32'h1235_5678, 8'h0, 0, 0, 0, "R7 data miss");
    bus(0, 0, 2'b10, 32'h2000, 32'h1234_5678, 8'h0, 0, 0, 0, "R3 operand vs fetch cond");
    cfg(4'd3, 32'h2001);
    bus(1, 0, 2'b10, 32'h2000, 32'h1234_5678, 8'h0, 0, 0, 0, "R3 odd fetch addr low");
    bus(1, 0, 2'b10, 32'h2002, 32'h1234_5678, 8'h0, 0, 0, 0, "R3 odd fetch addr high");
    cfg(4'd3, 32'h2000);

    cfg(4'd0, 32'h2000);
    bus(1, 0, 2'b10, 32'h2000, 32'h1234_0000, 8'h80, 1, 1, 1, "R8 both channels");
    clear_flags(2'b01);
    chk("R11 clear B keep A", {match_a_flag, match_b_flag}, {exp_fa, exp_fb});
    clear_flags(2'b11);
    chk("R11 write ones no effect", {match_a_flag, match_b_flag}, 2'b10);
    clear_flags(2'b00);
    chk("R11 clear both", {match_a_flag, match_b_flag}, 2'b00);

    // Sequence mode
    cfg(4'd8, 32'h1);
    cfg(4'd0, 32'h1000);
    bus(1, 0, 2'b10, 32'h2000, 32'h1234_0000, 8'h80, 0, 1, 0, "R9 B without A");
    bus(1, 0, 2'b10, 32'h1000, 32'h0, 8'h80, 1, 0, 0, "R9 A alone no break");
    bus(1, 0, 2'b10, 32'h2000, 32'h1234_0000, 8'h80, 0, 1, 1, "R9 B after A");
    bus(1, 0, 2'b10, 32'h2000, 32'h1234_0000, 8'h80, 0, 1, 0, "R9 record consumed");
    bus(1, 0, 2'b10, 32'h1000, 32'h0, 8'h80, 1, 0, 0, "R10 A before mode write");
    cfg(4'd8, 32'h1);
    bus(1, 0, 2'b10, 32'h2000, 32'h1234_0000, 8'h80, 0, 1, 0, "R10 mode write discards A");
    cfg(4'd0, 32'h2000);
    bus(1, 0, 2'b10, 32'h2000, 32'h1234_0000, 8'h80, 1, 1, 0, "R9 simultaneous A and B");
    bus(1, 0, 2'b10, 32'h2000, 32'h1234_0000, 8'h70, 0, 1, 1, "R9 A from simultaneous kept");
    chk("R11 flags sticky in sequence mode", {match_a_flag, match_b_flag}, 2'b11);

    cfg(4'd8, 32'h0);
    bus(1, 0, 2'b10, 32'h2000, 32'h1234_0000, 8'h70, 0, 1, 1, "R8 B alone independent");

    repeat (3) @(negedge clk);
    chk("R8 scoreboard drained", due_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule